// File: doc/BRIEF.md
# AT Command String Sequencer

This block drives a byte-wide UART transmitter so that a radio module is put into command mode and then configured, with no processor involved. On a start pulse it plays back a fixed script held in a small internal ROM. First comes the three-character escape string, which is sent with no line terminator. Then the block stays silent for a programmable guard interval. After that it sends each configuration command, one character at a time, and ends every command with a carriage return.

Each byte is handed to the transmitter with a single-clock valid strobe, and only after the transmitter has said it is ready. The module leaves command mode after three seconds of line silence, so the guard interval is set well below that. The bytes of each command follow one another as fast as the transmitter accepts them. When the script's end-of-list marker is reached, the block raises a done flag and returns to idle. The module's replies are not parsed.

Top module: `atcmd_sequencer`

## Requirements
- R1: A synchronous reset, active low, puts the block in idle with `tx_valid_o` low and `done_o` low. This holds even when the reset arrives in the middle of a script.
- R2: After a start, the bytes presented are, in order: "+++" (three 0x2B bytes), then "ATAP1", "ATWR" and "ATCN", each command followed by 0x0D. The escape string is never followed by 0x0D.
- R3: `tx_valid_o` is high for exactly one clock per byte and is never high in two consecutive clocks.
- R4: A byte is presented only in the clock after `tx_ready_i` was sampled high. While `tx_ready_i` stays low, no byte is presented.
- R5: After the last escape character, the block presents nothing for at least `GUARD_CYCLES` clocks, counting from that character's strobe to the strobe of the first command character.
- R6: In the ROM, the byte 0x00 ends a string and is never sent. For a command string it is replaced on the line by a carriage return (0x0D).
- R7: The ROM byte 0xFF marks the end of the script. On reaching it the block raises `done_o` and returns to idle. `done_o` then stays high and no further bytes are presented until the next start.
- R8: A start pulse that arrives while a script is running is ignored. The running script is neither restarted nor disturbed.
- R9: A start pulse in idle clears `done_o` and replays the whole script from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-clock request to run the script |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| tx_data_o | output | 8 | Byte presented to the transmitter |
| tx_valid_o | output | 1 | One-clock strobe qualifying `tx_data_o` |
| done_o | output | 1 | Script finished; held until the next start |

## Verification
The bench builds the block with `GUARD_CYCLES` set to 40 instead of the default of one second at 50 MHz. This lets the guard silence after the escape string be measured to the clock within a short run, and lets several complete scripts fit in the run. The transmitter model's busy time is changed between runs, from a single clock up to several clocks. A long forced not-ready window is also applied, so the pacing against ready is tested both at its tightest and while stalled. A late start, a mid-script reset and a replay after done are all run with this same small guard value.

// File: rtl/atcmd_pkg.sv
// Package: shared state encoding and special byte codes of the AT sequencer.
// Assumes: the script ROM uses these codes as string and list delimiters.
package atcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_GUARD = 2'd3
    } seq_state_e;

    localparam logic [7:0] CH_TERM = 8'h00;  // end of one string
    localparam logic [7:0] CH_END  = 8'hFF;  // end of the whole script
    localparam logic [7:0] CH_CR   = 8'h0D;  // line terminator for commands
    localparam logic [7:0] CH_PLUS = 8'h2B;  // escape character

endpackage

// File: rtl/atcmd_rom.sv
// Module: atcmd_rom
// Holds the fixed command script as bytes. The escape string comes first.
// Each string ends with CH_TERM, and the list ends with CH_END.
// Assumes: the address never goes past the CH_END entry. Locations past it
// read as CH_END, so a runaway address still stops the script.
module atcmd_rom
    import atcmd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    // Combinational lookup of one script byte.
    always_comb begin
        data_o = CH_END;
        if (int'(addr_i) < DEPTH) begin
            case (int'(addr_i))
                0:  data_o = CH_PLUS;
                1:  data_o = CH_PLUS;
                2:  data_o = CH_PLUS;
                3:  data_o = CH_TERM;
                4:  data_o = "A";
                5:  data_o = "T";
                6:  data_o = "A";
                7:  data_o = "P";
                8:  data_o = "1";
                9:  data_o = CH_TERM;
                10: data_o = "A";
                11: data_o = "T";
                12: data_o = "W";
                13: data_o = "R";
                14: data_o = CH_TERM;
                15: data_o = "A";
                16: data_o = "T";
                17: data_o = "C";
                18: data_o = "N";
                19: data_o = CH_TERM;
                default: data_o = CH_END;
            endcase
        end
    end

endmodule

// File: rtl/atcmd_guard_timer.sv
// Module: atcmd_guard_timer
// A down-counter for the silent gap after the escape string. A load pulse
// sets it to CYCLES. It then counts down by one each clock, and expired_o
// is high whenever the count is zero.
// Assumes: CYCLES >= 1 and below the module's three-second silence limit.
module atcmd_guard_timer #(
    parameter int CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R5: a running count only ever steps down by one.
    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: a load always starts a full guard window.
    a_r5_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/atcmd_sequencer.sv
// Module: atcmd_sequencer (top)
// Plays the ROM script into a byte-wide UART transmitter. It sends the
// escape string, waits out the guard time, then sends each command with a
// carriage return in place of the string terminator. Every byte costs one
// valid strobe, and it is issued only after tx_ready_i has been seen high.
// Assumes: once the transmitter accepts a byte it drops tx_ready_i on the
// clock after the strobe. The one-clock HOLD state covers that delay.
module atcmd_sequencer
    import atcmd_pkg::*;
#(
    parameter int GUARD_CYCLES = 50_000_000,
    parameter int ROM_AW       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tx_ready_i,
    output logic [7:0] tx_data_o,
    output logic       tx_valid_o,
    output logic       done_o
);

    seq_state_e        state_q;
    logic [ROM_AW-1:0] addr_q;
    logic              esc_q;       // still inside the escape string
    logic              load_q;      // one-clock guard timer load
    logic [7:0]        rom_byte;
    logic              guard_over;

    atcmd_rom #(
        .ADDR_W (ROM_AW)
    ) u_rom (
        .addr_i (addr_q),
        .data_o (rom_byte)
    );

    atcmd_guard_timer #(
        .CYCLES (GUARD_CYCLES)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_q),
        .expired_o (guard_over)
    );

    // Sequencing FSM: walks the ROM, paces against ready, raises done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            esc_q      <= 1'b0;
            load_q     <= 1'b0;
            tx_valid_o <= 1'b0;
            tx_data_o  <= '0;
            done_o     <= 1'b0;
        end else begin
            tx_valid_o <= 1'b0;
            load_q     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= '0;
                        esc_q   <= 1'b1;
                        done_o  <= 1'b0;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready_i) begin
                        if (rom_byte == CH_END) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (rom_byte == CH_TERM) begin
                            addr_q <= addr_q + 1'b1;
                            if (esc_q) begin
                                esc_q   <= 1'b0;
                                load_q  <= 1'b1;
                                state_q <= ST_GUARD;
                            end else begin
                                tx_data_o  <= CH_CR;
                                tx_valid_o <= 1'b1;
                                state_q    <= ST_HOLD;
                            end
                        end else begin
                            tx_data_o  <= rom_byte;
                            tx_valid_o <= 1'b1;
                            addr_q     <= addr_q + 1'b1;
                            state_q    <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    state_q <= ST_SEND;
                end
                ST_GUARD: begin
                    if (!load_q && guard_over) begin
                        state_q <= ST_SEND;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a strobe never lasts longer than one clock.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |=> !tx_valid_o);

    // R4: every strobe follows a clock in which ready was high.
    a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(tx_ready_i));

    // R5: the line stays quiet during the guard wait.
    a_r5_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD) |-> !tx_valid_o);

    // R7: done is only ever shown in idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_IDLE));

    // R8: a start seen while running does not rewind the script.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q != ST_IDLE) |=> (addr_q >= $past(addr_q)));

endmodule

// File: tb/atcmd_sequencer_bench.sv
// Scoreboard bench: the driver pushes the expected script bytes, and the
// monitor pops and compares them on each strobe. A simple transmitter model
// drives tx_ready_i.
module atcmd_sequencer_bench;

    localparam int GUARD = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       tx_ready_i;
    logic [7:0] tx_data_o;
    logic       tx_valid_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sent   = 0;
    int busy_len = 3;
    logic stall = 1'b0;
    logic model_ready;
    int   busy_cnt;
    logic [7:0] q[$];

    atcmd_sequencer #(
        .GUARD_CYCLES (GUARD),
        .ROM_AW       (5)
    ) u_atcmd_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tx_ready_i (tx_ready_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .done_o     (done_o)
    );

    always #2 clk = ~clk;

    assign tx_ready_i = model_ready && !stall;

    // Transmitter model: stays busy for busy_len clocks after each strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_ready <= 1'b1;
            busy_cnt    <= 0;
        end else if (tx_valid_o) begin
            model_ready <= 1'b0;
            busy_cnt    <= busy_len;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end else begin
            model_ready <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic push_str(input string s, input bit add_cr);
        for (int i = 0; i < s.len(); i++) q.push_back(s[i]);
        if (add_cr) q.push_back(8'h0D);
    endtask

    // Driver: the expected script for one run (R2, R6).
    task automatic push_script();
        push_str("+++", 1'b0);
        push_str("ATAP1", 1'b1);
        push_str("ATWR", 1'b1);
        push_str("ATCN", 1'b1);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done_o === 1'b1, "R7 done raised", int'(done_o), 1);
        check(q.size() == 0, "R2 script complete", q.size(), 0);
    endtask

    // Monitor: compares each strobed byte against the scoreboard.
    logic prev_valid = 1'b0;
    int   last_plus  = 0;
    bit   guard_pend = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && tx_valid_o) begin
            sent++;
            check(!prev_valid, "R3 strobe width", 1, 0);
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected byte", int'(tx_data_o), 0);
            end else begin
                logic [7:0] e;
                e = q.pop_front();
                if (e == 8'h0D) check(tx_data_o == e, "R6 carriage return", int'(tx_data_o), int'(e));
                else            check(tx_data_o == e, "R2 byte order", int'(tx_data_o), int'(e));
                if (e == 8'h2B) begin
                    last_plus  = cyc;
                    guard_pend = 1'b1;
                end else if (guard_pend) begin
                    guard_pend = 1'b0;
                    check(cyc - last_plus >= GUARD, "R5 guard gap", cyc - last_plus, GUARD);
                end
            end
        end
        prev_valid = rst_n && tx_valid_o;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R7 watchdog: actual timeout expected done");
            finish_run();
        end
    end

    initial begin
        int snap;
        rst_n   = 1'b0;
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_valid_o === 1'b0, "R1 reset valid", int'(tx_valid_o), 0);
        check(done_o === 1'b0, "R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;

        // Run 1: late start ignored (R8), ready stall (R4).
        push_script();
        pulse_start();
        wait (sent >= 6);
        pulse_start();          // R8: must not restart the script
        @(negedge clk) stall = 1'b1;
        repeat (2) @(negedge clk);
        snap = sent;
        repeat (60) @(negedge clk);
        check(sent == snap, "R4 no byte while not ready", sent, snap);
        stall = 1'b0;
        wait_done();

        // Idle after done: no bytes, done held (R7).
        snap = sent;
        repeat (40) @(negedge clk);
        check(done_o === 1'b1, "R7 done held", int'(done_o), 1);
        check(sent == snap, "R7 quiet after done", sent, snap);

        // Run 2: replay with the fastest transmitter (R9).
        busy_len = 0;
        push_script();
        pulse_start();
        @(negedge clk);
        check(done_o === 1'b0, "R9 done cleared", int'(done_o), 0);
        wait_done();

        // Run 3: reset in the middle of the script (R1).
        busy_len = 5;
        push_script();
        pulse_start();
        wait (sent >= 8);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_valid_o === 1'b0, "R1 mid-run reset valid", int'(tx_valid_o), 0);
        check(done_o === 1'b0, "R1 mid-run reset done", int'(done_o), 0);
        q.delete();
        guard_pend = 1'b0;
        rst_n = 1'b1;
        snap = sent;
        repeat (30) @(negedge clk);
        check(sent == snap, "R1 idle after reset", sent, snap);

        finish_run();
    end

endmodule